// File: doc/BRIEF.md
# ATM Transmit Cell Header Check and Payload Scrambler

This block sits in the transmit path of a cell-based link and handles one byte per clock of 53-byte cells. It works out the header check byte from the four leading header bytes and puts it into the fifth byte. Optionally it adds a fixed coset to that byte, and optionally it corrupts the byte once on purpose with a programmable pattern. It can also scramble the 48 payload bytes with a self-synchronising x^43+1 scrambler. A start-of-cell flag comes with the first byte of every cell. Each byte leaves the block one clock after it enters.

Software controls the block through a small register port with two addresses. Address 0 is an 8-bit control register. Address 1 is the error-pattern register. The block samples its settings once per cell, when the cell's first byte arrives. A cell is therefore never handled with a mix of old and new settings. The bit that requests error injection clears itself after it has been used once.

Top module: `atm_tx_cellgen`

## Requirements
- R1: After reset, control (address 0) reads 0x60. Bit 2 always reads 0. Bits 7,6,5,4,3,1,0 read back exactly as written. The pattern register (address 1) reads back its last write. Reads are combinational on `reg_addr`.
- R2: Each accepted byte appears on `out_data` one clock later with `out_valid` high. `out_soc` is high only for the byte that entered with `in_soc`. A cycle with `in_valid` low gives `out_valid` low. Cell bytes 1-4 leave unchanged.
- R3: With control bit 7 at 0, byte 5 leaves as the CRC-8 (generator x^8+x^2+x+1, MSB first, zero start) of bytes 1-4, plus any coset and error pattern.
- R4: With control bit 7 at 1, byte 5 leaves exactly as it was received.
- R5: With control bit 6 at 1 (and bit 7 at 0), the generated byte 5 is XORed with 0x55.
- R6: With control bit 4 at 1 when a cell starts, and bit 7 at 0, that cell's byte 5 is also XORed with the pattern register. This is applied after the coset. The following cells carry no pattern.
- R7: Bit 4 clears in the cycle that the corrupted byte 5 is accepted. A bus write in that same cycle cannot keep it set. While bit 7 is 1, the request stays pending.
- R8: With control bit 5 at 1, each payload byte (bytes 6-53) is scrambled MSB first: out = in XOR the scrambled bit 43 positions earlier. The history starts at zero after reset and runs on across cells. It changes only on bytes that are scrambled.
- R9: With control bit 5 at 0, payload bytes leave unchanged.
- R10: Settings are taken when byte 1 of a cell is accepted. A control write during a cell affects only later cells.
- R11: Valid bytes outside a cell leave unchanged, are never scrambled and have `out_soc` low. This covers bytes before the first start-of-cell and bytes after byte 53.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_soc | input | 1 | Marks byte 1 of a cell |
| in_data | input | 8 | Input byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = error pattern |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| out_valid | output | 1 | Output byte valid |
| out_soc | output | 1 | Output start-of-cell |
| out_data | output | 8 | Output byte |

## Verification
Every output byte is due exactly one clock after its input byte. The bench drives on the falling edge and samples 1 ns after the next rising edge, so it reads the result of the byte it just drove. Register effects show up on the combinational read port right after the rising edge that takes the write or the clear. Setting effects are checked on whole cells: the model takes the settings at byte 1, and the checks cover the cell in which a write lands as well as the cell after it. Gaps with `in_valid` low are checked one clock later for a low `out_valid`.

// File: rtl/atm_cg_pkg.sv
package atm_cg_pkg;

    localparam int          CELL_LEN      = 53;
    localparam int          HDR_LEN       = 5;
    localparam int          SCR_DELAY     = 43;
    localparam logic [7:0]  COSET_VAL     = 8'h55;
    localparam logic [7:0]  CRC_POLY      = 8'h07;
    localparam logic [7:0]  CTRL_RST      = 8'h60;
    localparam logic [7:0]  CTRL_RSV_MASK = 8'h04;

    typedef struct packed {
        logic hec_dis;
        logic coset_en;
        logic scr_en;
        logic err_ins;
        logic sync_pol;
        logic rsv;
        logic dss_tx_en;
        logic dss_rx_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEG_NONE = 2'd0,
        SEG_HDR  = 2'd1,
        SEG_HEC  = 2'd2,
        SEG_PAY  = 2'd3
    } seg_e;

    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic       fb;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            fb = r[7] ^ d[b];
            r  = {r[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
        end
        return r;
    endfunction

endpackage

// File: rtl/atm_cg_ctrl.sv
module atm_cg_ctrl
    import atm_cg_pkg::*;
#(
    parameter logic [7:0] RST_VAL  = CTRL_RST,
    parameter logic [7:0] RSV_MASK = CTRL_RSV_MASK
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       addr,
    input  logic [7:0] wdata,
    input  logic       clr_err,
    output logic [7:0] rdata,
    output ctrl_t      ctrl,
    output logic [7:0] pat
);
    ctrl_t      ctrl_q;
    logic [7:0] pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(RST_VAL);
            pat_q  <= 8'h00;
        end else begin
            if (we && !addr) ctrl_q <= ctrl_t'(wdata & ~RSV_MASK);
            if (we && addr)  pat_q  <= wdata;
            if (clr_err)     ctrl_q.err_ins <= 1'b0;
        end
    end

    assign rdata = addr ? pat_q : 8'(ctrl_q);
    assign ctrl  = ctrl_q;
    assign pat   = pat_q;

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (8'(ctrl_q) == RST_VAL));
    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !addr) |=> (ctrl_q.rsv == 1'b0));
    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_err |=> !ctrl_q.err_ins);
endmodule

// File: rtl/atm_cg_cellpos.sv
module atm_cg_cellpos
    import atm_cg_pkg::*;
#(
    parameter int CLEN = CELL_LEN,
    parameter int HLEN = HDR_LEN,
    localparam int IW  = $clog2(CLEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_soc,
    output logic [IW-1:0] idx,
    output seg_e          seg
);
    localparam logic [IW-1:0] LAST_IDX = IW'(CLEN - 1);
    localparam logic [IW-1:0] HEC_IDX  = IW'(HLEN - 1);

    logic [IW-1:0] cnt_q;
    logic          act_q;
    logic          cur_act;

    assign cur_act = in_soc | act_q;
    assign idx     = in_soc ? '0 : cnt_q;

    always_comb begin
        if (!cur_act)           seg = SEG_NONE;
        else if (idx < HEC_IDX) seg = SEG_HDR;
        else if (idx == HEC_IDX) seg = SEG_HEC;
        else                    seg = SEG_PAY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (in_valid) begin
            if (in_soc) begin
                cnt_q <= IW'(1);
                act_q <= 1'b1;
            end else if (act_q) begin
                cnt_q <= cnt_q + IW'(1);
                if (cnt_q == LAST_IDX) act_q <= 1'b0;
            end
        end
    end

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (cnt_q <= LAST_IDX));
endmodule

// File: rtl/atm_cg_hec.sv
module atm_cg_hec
    import atm_cg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic       first,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= 8'h00;
        else if (step) crc_q <= crc8_step(first ? 8'h00 : crc_q, din);
    end

    assign crc = crc_q;

    // R3
    crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(crc_q));
endmodule

// File: rtl/atm_cg_scram.sv
module atm_cg_scram
    import atm_cg_pkg::*;
#(
    parameter int DELAY = SCR_DELAY
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [DELAY-1:0] hist_q;
    logic [DELAY-1:0] hist_n;

    always_comb begin
        logic s;
        hist_n = hist_q;
        dout   = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            s       = din[b] ^ hist_n[DELAY-1];
            dout[b] = s;
            hist_n  = {hist_n[DELAY-2:0], s};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     hist_q <= '0;
        else if (en) hist_q <= hist_n;
    end

    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(hist_q));
endmodule

// File: rtl/atm_tx_cellgen.sv
module atm_tx_cellgen
    import atm_cg_pkg::*;
#(
    parameter int CLEN  = CELL_LEN,
    parameter int HLEN  = HDR_LEN,
    parameter int DELAY = SCR_DELAY,
    localparam int IW   = $clog2(CLEN + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_soc,
    input  logic [7:0] in_data,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       out_valid,
    output logic       out_soc,
    output logic [7:0] out_data
);
    ctrl_t         ctrl_live;
    logic [7:0]    pat_live;
    ctrl_t         cfg_q;
    logic [7:0]    pat_q;
    ctrl_t         cfg_eff;
    logic [7:0]    pat_eff;
    logic [IW-1:0] idx;
    seg_e          seg;
    logic [7:0]    crc;
    logic [7:0]    scr_out;
    logic [7:0]    hec_word;
    logic [7:0]    byte_nxt;
    logic          start;
    logic          clr_err;
    logic          scr_step;

    assign start   = in_valid && in_soc;
    assign cfg_eff = start ? ctrl_live : cfg_q;
    assign pat_eff = start ? pat_live  : pat_q;
    assign clr_err = in_valid && (seg == SEG_HEC) && cfg_eff.err_ins && !cfg_eff.hec_dis;
    assign scr_step = in_valid && (seg == SEG_PAY) && cfg_eff.scr_en;

    atm_cg_ctrl ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .clr_err (clr_err),
        .rdata   (reg_rdata),
        .ctrl    (ctrl_live),
        .pat     (pat_live)
    );

    atm_cg_cellpos #(.CLEN(CLEN), .HLEN(HLEN)) pos_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_soc   (in_soc),
        .idx      (idx),
        .seg      (seg)
    );

    atm_cg_hec hec_i (
        .clk   (clk),
        .rst   (rst),
        .step  (in_valid && (seg == SEG_HDR)),
        .first (idx == '0),
        .din   (in_data),
        .crc   (crc)
    );

    atm_cg_scram #(.DELAY(DELAY)) scr_i (
        .clk  (clk),
        .rst  (rst),
        .en   (scr_step),
        .din  (in_data),
        .dout (scr_out)
    );

    assign hec_word = crc
                    ^ (cfg_eff.coset_en ? COSET_VAL : 8'h00)
                    ^ (cfg_eff.err_ins  ? pat_eff   : 8'h00);

    always_comb begin
        unique case (seg)
            SEG_HEC: byte_nxt = cfg_eff.hec_dis ? in_data : hec_word;
            SEG_PAY: byte_nxt = cfg_eff.scr_en  ? scr_out : in_data;
            default: byte_nxt = in_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= ctrl_t'(CTRL_RST);
            pat_q     <= 8'h00;
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= 8'h00;
        end else begin
            if (start) begin
                cfg_q <= ctrl_live;
                pat_q <= pat_live;
            end
            out_valid <= in_valid;
            out_soc   <= start;
            if (in_valid) out_data <= byte_nxt;
        end
    end

    // R2
    soc_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_soc |-> out_valid);
    // R2
    hdr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seg == SEG_HDR) |=> (out_data == $past(in_data)));
    // R4
    hec_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seg == SEG_HEC && cfg_eff.hec_dis) |=> (out_data == $past(in_data)));
    // R9
    pay_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seg == SEG_PAY && !cfg_eff.scr_en) |=> (out_data == $past(in_data)));
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cfg_q));
endmodule

// File: tb/atm_tx_cellgen_tb_top.sv
module atm_tx_cellgen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_soc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       out_valid;
    logic       out_soc;
    logic [7:0] out_data;

    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] m_ctrl = 8'h60;
    logic [7:0] m_pat = 8'h00;
    logic [42:0] m_hist = '0;

    always #2 clk = ~clk;

    atm_tx_cellgen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [31:0] h);
        logic [39:0] r;
        r = {h, 8'h00};
        for (int i = 39; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    task automatic scr_model(input logic [7:0] d, output logic [7:0] o);
        logic s;
        for (int b = 7; b >= 0; b--) begin
            s      = d[b] ^ m_hist[42];
            o[b]   = s;
            m_hist = {m_hist[41:0], s};
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (!a) m_ctrl = v & 8'hFB; else m_pat = v;
    endtask

    task automatic reg_read(input logic a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic stray(input int n);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'(k * 37 + 11);
            @(negedge clk);
            in_valid = 1'b1; in_soc = 1'b0; in_data = d;
            @(posedge clk); #1;
            chk("R11 stray byte", {22'h0, out_valid, out_soc, out_data}, {22'h0, 1'b1, 1'b0, d});
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_cell(input logic [31:0] hdr, input logic [7:0] hec_in, input int seed,
                             input int wr_at, input logic [7:0] wr_val, input bit gaps,
                             input string hec_req);
        logic [7:0] cfg, pat, crc, d, e;
        string      rq;
        cfg = m_ctrl; pat = m_pat; crc = ref_crc(hdr);
        for (int k = 0; k < 53; k++) begin
            if (k < 4)       d = hdr[31 - 8*k -: 8];
            else if (k == 4) d = hec_in;
            else             d = 8'(seed * 29 + k * 13 + (k * k));
            if (k < 4) begin
                e = d; rq = "R2 header";
            end else if (k == 4) begin
                e = cfg[7] ? d : (crc ^ (cfg[6] ? 8'h55 : 8'h00) ^ (cfg[4] ? pat : 8'h00));
                rq = hec_req;
            end else if (cfg[5]) begin
                scr_model(d, e); rq = "R8 payload";
            end else begin
                e = d; rq = "R9 payload";
            end
            @(negedge clk);
            in_valid = 1'b1; in_soc = (k == 0); in_data = d;
            if (k == wr_at) begin
                reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = wr_val;
            end
            @(posedge clk); #1;
            reg_we = 1'b0;
            if (k == wr_at) m_ctrl = wr_val & 8'hFB;
            if (k == 4 && cfg[4] && !cfg[7]) m_ctrl[4] = 1'b0;
            chk(rq, {22'h0, out_valid, out_soc, out_data}, {22'h0, 1'b1, (k == 0), e});
            if (gaps && (k % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(posedge clk); #1;
                chk("R2 gap", {31'h0, out_valid}, 32'h0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_soc = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R2 reset out_valid", {31'h0, out_valid}, 32'h0);
        // R1 reset value
        reg_read(1'b0, 8'h60, "R1 reset ctrl");
        // R11 bytes before first cell, scrambler enabled but must not act
        stray(6);
        // R1 readback and reserved bit
        reg_write(1'b0, 8'hFF);
        reg_read(1'b0, 8'hFB, "R1 readback all ones");
        reg_write(1'b0, 8'h0B);
        reg_read(1'b0, 8'h0B, "R1 polarity and dss bits");
        reg_write(1'b1, 8'hA5);
        reg_read(1'b1, 8'hA5, "R1 pattern readback");
        // sweep of hec_dis / coset / scrambler settings (R3 R4 R5 R8 R9)
        for (int m = 0; m < 8; m++) begin
            reg_write(1'b0, {m[2:0], 5'b0});
            for (int c = 0; c < 4; c++)
                send_cell($urandom, 8'($urandom), m * 4 + c, -1, 8'h00, (c == 1),
                          m[2] ? "R4 hec pass" : (m[1] ? "R5 coset" : "R3 hec"));
        end
        // R11 bytes after a cell end with scrambler on
        reg_write(1'b0, 8'h20);
        send_cell($urandom, 8'h00, 90, -1, 8'h00, 1'b0, "R3 hec");
        stray(4);
        send_cell($urandom, 8'h00, 91, -1, 8'h00, 1'b0, "R3 hec");
        // R6 one-shot error with coset
        reg_write(1'b1, 8'h3C);
        reg_write(1'b0, 8'h50);
        send_cell($urandom, 8'h00, 92, -1, 8'h00, 1'b0, "R6 error cell");
        reg_read(1'b0, 8'h40, "R7 auto clear");
        send_cell($urandom, 8'h00, 93, -1, 8'h00, 1'b0, "R6 next cell clean");
        // R7 clear beats write in same cycle
        reg_write(1'b0, 8'h10);
        send_cell($urandom, 8'h00, 94, 4, 8'h50, 1'b0, "R6 error cell collision");
        reg_read(1'b0, 8'h40, "R7 clear wins over write");
        // R7 request pending while hec generation disabled
        reg_write(1'b0, 8'h90);
        send_cell($urandom, 8'h77, 95, -1, 8'h00, 1'b0, "R4 hec pass err pending");
        reg_read(1'b0, 8'h90, "R7 pending while disabled");
        reg_write(1'b0, 8'h10);
        send_cell($urandom, 8'h00, 96, -1, 8'h00, 1'b0, "R6 deferred error");
        reg_read(1'b0, 8'h00, "R7 clear after deferred");
        // R10 mid-cell write applies to next cell only
        reg_write(1'b0, 8'h00);
        send_cell($urandom, 8'h00, 97, 10, 8'h60, 1'b0, "R10 old settings");
        reg_read(1'b0, 8'h60, "R10 write landed");
        send_cell($urandom, 8'h00, 98, -1, 8'h00, 1'b0, "R10 new settings");
        send_cell(32'h00000000, 8'h00, 99, -1, 8'h00, 1'b0, "R5 zero header coset");
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule